// File: doc/BRIEF.md
# Packet-to-Burst Framer

The framer takes packets from a first-word-fall-through queue, one 64-bit word per cycle, each word marked with start-of-packet and end-of-packet flags. It emits a stream of 64-bit words, each tagged as either payload or control. A packet opens with a burst control word. Payload is cut into bursts of at most `BURST_MAX` words, with a fresh burst control word between bursts. The packet closes with an end-of-packet control word. A closing burst shorter than `BURST_SHORT` is followed by idle words until it reaches that length. Every control and idle word carries a CRC-24. The CRC covers the payload sent since the previous control word, followed by the word itself with its CRC field taken as zero.

The framer pulls a word from the queue only in a cycle where it forwards that word or discards it. While it inserts a control or idle word, the word at the head of the queue waits. Outputs are registered, and a word appears on the output one cycle after the cycle in which it was chosen. Input stalls show as cycles with `out_valid_o` low.

Top module: `burst_framer`

## Requirements
- R1: After reset the framer waits in idle. It emits nothing and reads nothing while `enable_i` is low, even when a start-of-packet word is waiting. Once enabled, a start-of-packet word at the queue head begins a packet.
- R2: While idle and enabled, a valid word without the start flag is read from the queue and discarded, and no output word is produced for it.
- R3: A packet's output begins with a burst control word whose bit 61 (start) is 1. The packet words follow unchanged and in order, each with `out_ctrl_o` low.
- R4: Once a burst holds `BURST_MAX` payload words and the packet has more words, exactly one burst control word is inserted, with bit 61 = 0, bits 60:57 = 0 and bit 31 = 0. Payload then resumes. No burst carries more than `BURST_MAX` payload words.
- R5: The output word after the end-of-packet payload word is a control word with bits 60:57 = 4'b1000. If the last burst already holds `BURST_MAX` words, no burst control word is inserted before it.
- R6: If the last burst of a packet holds L payload words with L < `BURST_SHORT`, then `BURST_SHORT` - L idle words follow the end-of-packet word. An idle word is a control word with bit 31 = 1, bit 61 = 0 and bits 60:57 = 0. If L ≥ `BURST_SHORT`, no idle word follows. The next packet may start in the cycle right after the last idle word.
- R7: Bits 23:0 of every control and idle word hold a CRC-24 with polynomial 0x328B63 and seed 0xFFFFFF. The CRC is computed most significant bit first, with no final inversion. It runs over the payload words since the previous control or idle word, then over the word itself with bits 23:0 taken as zero.
- R8: `in_rd_o` is never high without `in_valid_i`, and it is low in every cycle that produces a control or idle word. Each packet word is read exactly once.
- R9: In every control and idle word, bits 63 and 62 are 1, bits 39:32 carry `CHANNEL`, and bits 56:40 and 30:24 are 0. `out_ctrl_o` is high exactly for control and idle words.
- R10: During and straight after reset, `out_valid_o` and `in_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Allows a new packet to start |
| in_valid_i | input | 1 | Queue head word is present |
| in_data_i | input | 64 | Queue head word |
| in_sop_i | input | 1 | Queue head word starts a packet |
| in_eop_i | input | 1 | Queue head word ends a packet |
| in_rd_o | output | 1 | Pops the queue head word in this cycle |
| out_valid_o | output | 1 | Output word present |
| out_ctrl_o | output | 1 | Output word is a control or idle word |
| out_data_o | output | 64 | Output word |

## Verification
A wrong burst counter shows at the ports within one burst. It appears as a burst control word at the wrong payload position, as a missing or extra idle word after the end-of-packet word, or as a payload run longer than `BURST_MAX`. A corrupted running CRC changes bits 23:0 of the very next control word. A wrong sequencer state shows up as a queue pop during a control cycle or as a lost or repeated payload word, which breaks the word order one cycle later. The bench compares every output word against a model built from the requirements, so each of these faults fails the packet in which it first occurs.

// File: rtl/burst_framer_pkg.sv
package burst_framer_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned CRC_W  = 24;
  localparam logic [CRC_W-1:0] CRC_POLY = 24'h328B63;
  localparam logic [CRC_W-1:0] CRC_SEED = 24'hFFFFFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_EOP,
    ST_PAD
  } seq_state_e;

  typedef enum logic [1:0] {
    EM_NONE,
    EM_DATA,
    EM_CTRL
  } emit_e;

  typedef struct packed {
    logic sop;
    logic eop;
    logic idle;
  } ctrl_sel_t;

  // One 64-bit word folded into a CRC-24, most significant bit first.
  function automatic logic [CRC_W-1:0] crc24_fold(input logic [CRC_W-1:0] crc_in,
                                                  input logic [WORD_W-1:0] word);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ word[b];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  // Control word with an all-zero CRC field.
  function automatic logic [WORD_W-1:0] ctrl_template(input ctrl_sel_t sel,
                                                      input logic [7:0] chan);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[63]    = 1'b1;
    w[62]    = 1'b1;
    w[61]    = sel.sop;
    w[60:57] = sel.eop ? 4'b1000 : 4'b0000;
    w[39:32] = chan;
    w[31]    = sel.idle;
    return w;
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_framer_pkg::*;
#(
  parameter int unsigned BURST_MAX   = 32,
  parameter int unsigned BURST_SHORT = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable_i,
  input  logic      in_valid_i,
  input  logic      in_sop_i,
  input  logic      in_eop_i,
  output logic      in_rd_o,
  output emit_e     emit_o,
  output ctrl_sel_t sel_o
);

  localparam int unsigned CNT_W = $clog2(BURST_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(BURST_MAX);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(BURST_SHORT);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    in_rd_o = 1'b0;
    emit_o  = EM_NONE;
    sel_o   = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (enable_i && in_valid_i) begin
          if (in_sop_i) begin
            emit_o    = EM_CTRL;
            sel_o.sop = 1'b1;
            cnt_d     = '0;
            st_d      = ST_DATA;
          end else begin
            in_rd_o = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (cnt_q == CNT_MAX) begin
          emit_o = EM_CTRL;
          cnt_d  = '0;
        end else if (in_valid_i) begin
          emit_o  = EM_DATA;
          in_rd_o = 1'b1;
          cnt_d   = cnt_inc;
          if (in_eop_i) begin
            st_d = ST_EOP;
          end
        end
      end
      ST_EOP: begin
        emit_o    = EM_CTRL;
        sel_o.eop = 1'b1;
        st_d      = (cnt_q < CNT_SHORT) ? ST_PAD : ST_IDLE;
      end
      ST_PAD: begin
        emit_o     = EM_CTRL;
        sel_o.idle = 1'b1;
        cnt_d      = cnt_inc;
        if (cnt_inc >= CNT_SHORT) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  assign cnt_en = (emit_o != EM_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_crc.sv
module burst_crc
  import burst_framer_pkg::*;
#(
  parameter logic [7:0] CHANNEL = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  emit_e             emit_i,
  input  ctrl_sel_t         sel_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              is_ctrl_o
);

  logic [CRC_W-1:0]  crc_q, crc_d;
  logic              crc_en;
  logic [WORD_W-1:0] ctrl_zero;
  logic [CRC_W-1:0]  ctrl_crc;

  assign ctrl_zero = ctrl_template(sel_i, CHANNEL);
  assign ctrl_crc  = crc24_fold(crc_q, ctrl_zero);

  always_comb begin
    crc_d = crc_q;
    if (emit_i == EM_DATA) begin
      crc_d = crc24_fold(crc_q, data_i);
    end else if (emit_i == EM_CTRL) begin
      crc_d = CRC_SEED;
    end
  end

  assign crc_en = (emit_i != EM_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign is_ctrl_o = (emit_i == EM_CTRL);
  assign word_o    = is_ctrl_o ? {ctrl_zero[WORD_W-1:CRC_W], ctrl_crc} : data_i;

endmodule

// File: rtl/burst_outreg.sv
module burst_outreg
  import burst_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  emit_e             emit_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ctrl_i,
  output logic              out_valid_o,
  output logic              out_ctrl_o,
  output logic [WORD_W-1:0] out_data_o
);

  logic load;

  assign load = (emit_i != EM_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_ctrl_o <= 1'b0;
      out_data_o <= '0;
    end else if (load) begin
      out_ctrl_o <= ctrl_i;
      out_data_o <= word_i;
    end
  end

endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import burst_framer_pkg::*;
#(
  parameter int unsigned BURST_MAX   = 32,
  parameter int unsigned BURST_SHORT = 4,
  parameter logic [7:0]  CHANNEL     = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable_i,
  input  logic        in_valid_i,
  input  logic [63:0] in_data_i,
  input  logic        in_sop_i,
  input  logic        in_eop_i,
  output logic        in_rd_o,
  output logic        out_valid_o,
  output logic        out_ctrl_o,
  output logic [63:0] out_data_o
);

  generate
    if (BURST_SHORT < 1 || BURST_SHORT >= BURST_MAX) begin : g_bad_lengths
      $error("burst_framer: need 1 <= BURST_SHORT < BURST_MAX");
    end
  endgenerate

  emit_e             emit;
  ctrl_sel_t         sel;
  logic [WORD_W-1:0] word;
  logic              is_ctrl;

  burst_seq #(
    .BURST_MAX  (BURST_MAX),
    .BURST_SHORT(BURST_SHORT)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .in_valid_i(in_valid_i),
    .in_sop_i  (in_sop_i),
    .in_eop_i  (in_eop_i),
    .in_rd_o   (in_rd_o),
    .emit_o    (emit),
    .sel_o     (sel)
  );

  burst_crc #(
    .CHANNEL(CHANNEL)
  ) crc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .emit_i   (emit),
    .sel_i    (sel),
    .data_i   (in_data_i),
    .word_o   (word),
    .is_ctrl_o(is_ctrl)
  );

  burst_outreg out_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit_i     (emit),
    .word_i     (word),
    .ctrl_i     (is_ctrl),
    .out_valid_o(out_valid_o),
    .out_ctrl_o (out_ctrl_o),
    .out_data_o (out_data_o)
  );

endmodule

// File: rtl/burst_framer_chk.sv
module burst_framer_chk #(
  parameter int unsigned BURST_MAX = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid_i,
  input logic [63:0] in_data_i,
  input logic        in_eop_i,
  input logic        in_rd_o,
  input logic        out_valid_o,
  input logic        out_ctrl_o,
  input logic [63:0] out_data_o
);

  localparam int unsigned RUN_W = $clog2(BURST_MAX + 1) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (out_valid_o) begin
      if (out_ctrl_o) begin
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R8: a pop only happens with a word present
  a_r8_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd_o |-> in_valid_i);

  // R8: a control word is produced in a cycle without a pop
  a_r8_ctrl_holds_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ctrl_o) |-> !$past(in_rd_o));

  // R3: each payload output is the word popped one cycle earlier
  a_r3_payload_from_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ctrl_o) |-> ($past(in_rd_o) && (out_data_o == $past(in_data_i))));

  // R5: the end-of-packet control word follows the last payload word directly
  a_r5_eop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ctrl_o && $past(in_eop_i)) |=>
      (out_valid_o && out_ctrl_o && (out_data_o[60:57] == 4'b1000)));

  // R4: no burst grows past the maximum length
  a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ctrl_o) |-> (run_q < RUN_W'(BURST_MAX)));

  // R9: control words carry both marker bits
  a_r9_ctrl_markers: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ctrl_o) |-> (out_data_o[63:62] == 2'b11));

endmodule

bind burst_framer burst_framer_chk #(
  .BURST_MAX(BURST_MAX)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .in_eop_i   (in_eop_i),
  .in_rd_o    (in_rd_o),
  .out_valid_o(out_valid_o),
  .out_ctrl_o (out_ctrl_o),
  .out_data_o (out_data_o)
);

// File: tb/burst_framer_tb_top.sv
`timescale 1ns/1ps
module burst_framer_tb_top;

  localparam int unsigned BMAX   = 8;
  localparam int unsigned BSHORT = 4;
  localparam logic [7:0]  CHAN   = 8'h3C;
  localparam int          NVEC   = 11;
  // [23:16] packet length, [15:8] bubble period (0 = none), [7:0] expected output words
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01_00_06, 24'h03_02_06, 24'h04_00_06, 24'h05_03_07,
    24'h08_00_0A, 24'h09_01_0F, 24'h0B_00_0F, 24'h0C_04_0F,
    24'h10_00_13, 24'h11_02_18, 24'h18_00_1C
  };

  logic        clk, rst_n, enable_i, in_valid_i, in_sop_i, in_eop_i;
  logic [63:0] in_data_i;
  logic        in_rd_o, out_valid_o, out_ctrl_o;
  logic [63:0] out_data_o;

  burst_framer #(
    .BURST_MAX(BMAX), .BURST_SHORT(BSHORT), .CHANNEL(CHAN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .in_sop_i(in_sop_i), .in_eop_i(in_eop_i),
    .in_rd_o(in_rd_o), .out_valid_o(out_valid_o), .out_ctrl_o(out_ctrl_o),
    .out_data_o(out_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  int          pops  = 0;
  logic [66:0] in_q[$];   // [66] bubble, [65] sop, [64] eop, [63:0] data
  logic [64:0] obs_q[$];  // [64] ctrl flag, [63:0] word
  logic [64:0] exp_q[$];
  logic [63:0] first_w;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] crc_ref(input logic [23:0] crc, input logic [63:0] w);
    int unsigned r;
    r = crc;
    for (int k = 0; k < 64; k++) begin
      if ((((r >> 23) & 1) ^ w[63-k]) != 0) r = ((r << 1) ^ 32'h328B63) & 32'hFFFFFF;
      else r = (r << 1) & 32'hFFFFFF;
    end
    return r[23:0];
  endfunction

  function automatic logic [63:0] ctrl_ref(input bit sop, input bit eop, input bit idle,
                                           input logic [23:0] run);
    logic [63:0] w;
    w = 64'h0;
    w[63] = 1'b1; w[62] = 1'b1; w[61] = sop;
    w[60] = eop;
    w[39:32] = CHAN; w[31] = idle;
    w[23:0] = crc_ref(run, w);
    return w;
  endfunction

  function automatic logic [63:0] mkdata(input int tagv, input int i);
    return {16'(tagv) ^ 16'h8000, 16'(i), 32'(i) * 32'h9E3779B9 ^ 32'(tagv)};
  endfunction

  task automatic add_pkt(input int len, input int gap, input int tagv);
    logic [23:0] run;
    int          chunk;
    logic [63:0] d;
    run = 24'hFFFFFF;
    exp_q.push_back({1'b1, ctrl_ref(1, 0, 0, run)});
    chunk = 0;
    for (int i = 0; i < len; i++) begin
      d = mkdata(tagv, i);
      if (gap != 0 && (i % gap) == 0) in_q.push_back({1'b1, 66'h0});
      in_q.push_back({1'b0, (i == 0), (i == len - 1), d});
      if (chunk == BMAX) begin
        exp_q.push_back({1'b1, ctrl_ref(0, 0, 0, run)});
        run = 24'hFFFFFF;
        chunk = 0;
      end
      exp_q.push_back({1'b0, d});
      run = crc_ref(run, d);
      chunk++;
    end
    exp_q.push_back({1'b1, ctrl_ref(0, 1, 0, run)});
    for (int p = chunk; p < BSHORT; p++) exp_q.push_back({1'b1, ctrl_ref(0, 0, 1, 24'hFFFFFF)});
  endtask

  task automatic run_and_compare(input string req, input int exp_n);
    int bad;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (in_q.size() == 0 && obs_q.size() >= exp_q.size()) break;
    end
    repeat (12) @(negedge clk);
    check(obs_q.size() == exp_n, req, "output word count", 64'(obs_q.size()), 64'(exp_n));
    bad = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (bad < 0 && (i >= obs_q.size() || obs_q[i] !== exp_q[i])) bad = i;
    end
    if (bad >= 0) begin
      check(1'b0, req, $sformatf("word %0d content", bad),
            (bad < obs_q.size()) ? obs_q[bad][63:0] : 64'hX, exp_q[bad][63:0]);
    end else begin
      check(1'b1, req, "content", 64'h0, 64'h0);
    end
    first_w = (obs_q.size() > 0) ? obs_q[0][63:0] : 64'h0;
    obs_q.delete();
    exp_q.delete();
  endtask

  // input driver: first-word-fall-through queue model
  initial begin
    bit took, bub;
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0; in_data_i = 64'h0;
    forever begin
      @(negedge clk);
      bub = 1'b0;
      if (in_q.size() > 0 && !in_q[0][66]) begin
        in_valid_i = 1'b1; in_sop_i = in_q[0][65]; in_eop_i = in_q[0][64];
        in_data_i = in_q[0][63:0];
      end else begin
        in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
        bub = (in_q.size() > 0);
      end
      #2;
      took = in_rd_o;
      @(posedge clk);
      if (bub) void'(in_q.pop_front());
      else if (took && in_q.size() > 0) begin
        void'(in_q.pop_front());
        pops++;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid_o) obs_q.push_back({out_ctrl_o, out_data_o});
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enable_i = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid_o == 1'b0 && in_rd_o == 1'b0, "R10", "outputs in reset",
          {62'h0, out_valid_o, in_rd_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0 && in_rd_o == 1'b0, "R10", "outputs after reset",
          {62'h0, out_valid_o, in_rd_o}, 64'h0);

    // R1: disabled framer leaves a waiting packet untouched
    pops = 0;
    add_pkt(2, 0, 1);
    repeat (12) @(negedge clk);
    check(obs_q.size() == 0, "R1", "outputs while disabled", 64'(obs_q.size()), 64'h0);
    check(pops == 0, "R1", "pops while disabled", 64'(pops), 64'h0);
    enable_i = 1'b1;
    run_and_compare("R1", 6);

    // R2: stray non-start words are discarded while idle
    pops = 0;
    in_q.push_back({3'b000, 64'hDEAD_0000_0000_0001});
    in_q.push_back({3'b000, 64'hDEAD_0000_0000_0002});
    add_pkt(2, 0, 2);
    run_and_compare("R2", 6);
    check(pops == 4, "R2", "pops incl. discarded", 64'(pops), 64'h4);
    check(first_w[61] == 1'b1 && first_w[63:62] == 2'b11, "R3", "first word is start control",
          first_w, 64'hE000_0000_0000_0000);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      pops = 0;
      add_pkt(int'(VEC[v][23:16]), int'(VEC[v][15:8]), 16 + v);
      run_and_compare($sformatf("R3 R4 R5 R6 R7 vec%0d", v), int'(VEC[v][7:0]));
      check(pops == int'(VEC[v][23:16]), "R8", $sformatf("pops vec%0d", v),
            64'(pops), 64'(VEC[v][23:16]));
    end

    // R6: next packet starts straight after padding
    add_pkt(1, 0, 40);
    add_pkt(13, 0, 41);
    run_and_compare("R6 back-to-back", 22);

    // R9: control word fixed fields
    check(first_w[39:32] == CHAN, "R9", "channel field", {56'h0, first_w[39:32]}, {56'h0, CHAN});
    check(first_w[56:40] == 17'h0 && first_w[30:24] == 7'h0, "R9", "reserved fields",
          first_w, {first_w[63:57], 17'h0, first_w[39:31], 7'h0, first_w[23:0]});

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule